// File: doc/BRIEF.md
# Distributed Arithmetic 3x3 Convolution Engine

This block forms the dot product of nine signed input samples against nine fixed signed weights, the core operation of a 3x3 convolution window, without any multiplier. Every signed sum of a subset of the weights is computed ahead of time by software and written into a lookup table of 2^9 entries. A convolution then takes one bit position of all nine inputs per cycle, uses those nine bits as the table address, and folds the looked-up partial sum into a single shift-accumulate register.

Bit positions are visited from the most significant down. The sign slice is subtracted and all other slices are added, which gives a correct two's-complement product. The accumulate step is a ripple of majority-carry and XOR-sum cells. The table must be loaded while the engine is idle. A convolution begins with a one-cycle `start` that carries all nine input words at once. The engine then raises `busy` and some cycles later pulses `done`. `result` keeps its value until the next accepted start.

Top module: `da_conv_engine`

## Requirements
- R1: With table entry at address a holding the sum of the weights h_i for which bit i of a is 1, `result` equals the signed sum of x_i*h_i. Input word i sits in bits [8i+7:8i] of `in_data`, and bit i of the table address is taken from input word i.
- R2: A start is accepted when `start` is 1 and `busy` is 0 at a rising clock edge. `done` is 1 for exactly one cycle, which begins 9 clock edges after that edge (8 bit slices plus one cycle of table read).
- R3: `busy` is 1 from the accepting edge until the edge that raises `done`, and is 0 while `done` is 1.
- R4: `start` while `busy` is 1 is ignored; neither the timing of `done` nor `result` changes.
- R5: The input words are captured at the accepting edge; later changes of `in_data` do not affect the result.
- R6: After `done`, `result` stays constant until the next accepted start.
- R7: Table writes (`tbl_we`=1) while `busy` is 1 are ignored, both for the running convolution and for later ones.
- R8: The sign bit slice is subtracted: all nine inputs at -128 give -128 times the sum of the weights.
- R9: After reset `busy`, `done` and `result` are 0.
- R10: The accumulator cannot overflow: all weights and all inputs at -128 give +147456, and all inputs at 127 with all weights at -128 give -146304.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write enable, honoured only while idle |
| tbl_addr | input | 9 | Table write address (one bit per input) |
| tbl_wdata | input | 12 | Signed partial sum to store |
| start | input | 1 | Begin a convolution with `in_data` |
| in_data | input | 72 | Nine signed 8-bit input words, word i in bits [8i+7:8i] |
| busy | output | 1 | Convolution in progress |
| done | output | 1 | One-cycle pulse when `result` is final |
| result | output | 20 | Signed dot product |

## Verification
A bit-index counter that is off by one shifts every partial sum by a power of two. That shows at the very next `done` as a result scaled or offset from the direct multiply-accumulate, and a vector with only one input bit set locates the error. If the sign flag lands on the wrong slice, any negative input corrupts the result, and the all -128 corner exposes it within one convolution. Sequencer faults in accepting a start or in counting to the end show as `done` one cycle early or late, or as a `busy` that restarts. A table write that slips through while busy corrupts the running or the following result on inputs whose slices address the overwritten entry.

// File: rtl/da_conv_pkg.sv
package da_conv_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_RUN   = 2'd1,
      SEQ_DRAIN = 2'd2
   } seq_state_e;

   function automatic int min_lut_width(input int in_w, input int taps);
      return in_w + $clog2(taps + 1);
   endfunction

endpackage

// File: rtl/da_lut_mem.sv
module da_lut_mem #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rd_en)
         rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/da_slice_seq.sv
module da_slice_seq
   import da_conv_pkg::*;
#(
   parameter int N_TAPS = 9,
   parameter int IN_W   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [N_TAPS*IN_W-1:0] in_data,
   output logic                   busy,
   output logic                   accept,
   output logic                   rd_en,
   output logic [N_TAPS-1:0]      slice_addr,
   output logic                   step_vld,
   output logic                   step_sub,
   output logic                   done
);
   localparam int BIT_W = (IN_W > 1) ? $clog2(IN_W) : 1;
   localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(IN_W - 1);

   seq_state_e        state;
   logic [BIT_W-1:0]  bit_idx;
   logic              step_last;
   logic [IN_W-1:0]   word_q [N_TAPS];

   assign busy   = (state != SEQ_IDLE);
   assign accept = start && (state == SEQ_IDLE);
   assign rd_en  = (state == SEQ_RUN);

   genvar gi;
   generate
      for (gi = 0; gi < N_TAPS; gi++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q[gi] <= '0;
            else if (accept)
               word_q[gi] <= in_data[gi*IN_W +: IN_W];
         end
         assign slice_addr[gi] = word_q[gi][bit_idx];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         bit_idx   <= '0;
         step_vld  <= 1'b0;
         step_sub  <= 1'b0;
         step_last <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= step_vld && step_last;
         unique case (state)
            SEQ_IDLE: begin
               step_vld  <= 1'b0;
               step_sub  <= 1'b0;
               step_last <= 1'b0;
               if (accept) begin
                  state   <= SEQ_RUN;
                  bit_idx <= TOP_BIT;
               end
            end
            SEQ_RUN: begin
               step_vld  <= 1'b1;
               step_sub  <= (bit_idx == TOP_BIT);
               step_last <= (bit_idx == '0);
               if (bit_idx == '0)
                  state <= SEQ_DRAIN;
               else
                  bit_idx <= bit_idx - 1'b1;
            end
            SEQ_DRAIN: begin
               step_vld  <= 1'b0;
               step_sub  <= 1'b0;
               step_last <= 1'b0;
               state     <= SEQ_IDLE;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc #(
   parameter int LUT_W        = 12,
   parameter int ACC_W        = 20,
   parameter bit ADDER_RIPPLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step_vld,
   input  logic             step_sub,
   input  logic [LUT_W-1:0] part_sum,
   output logic [ACC_W-1:0] acc
);
   logic [ACC_W-1:0] shifted;
   logic [ACC_W-1:0] operand;
   logic [ACC_W-1:0] sum;

   assign shifted = {acc[ACC_W-2:0], 1'b0};
   assign operand = {{(ACC_W-LUT_W){part_sum[LUT_W-1]}}, part_sum} ^ {ACC_W{step_sub}};

   generate
      if (ADDER_RIPPLE) begin : g_ripple
         logic [ACC_W:0] carry;
         assign carry[0] = step_sub;
         for (genvar k = 0; k < ACC_W; k++) begin : g_cell
            assign carry[k+1] = (shifted[k] & operand[k]) |
                                (shifted[k] & carry[k])   |
                                (operand[k] & carry[k]);
            assign sum[k] = shifted[k] ^ operand[k] ^ carry[k];
         end
      end else begin : g_behav
         assign sum = shifted + operand + ACC_W'(step_sub);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (clr)
         acc <= '0;
      else if (step_vld)
         acc <= sum;
   end
endmodule

// File: rtl/da_conv_engine.sv
module da_conv_engine
   import da_conv_pkg::*;
#(
   parameter int N_TAPS       = 9,
   parameter int IN_W         = 8,
   parameter int LUT_W        = 12,
   parameter int ACC_W        = 20,
   parameter bit ADDER_RIPPLE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tbl_we,
   input  logic [N_TAPS-1:0]      tbl_addr,
   input  logic [LUT_W-1:0]       tbl_wdata,
   input  logic                   start,
   input  logic [N_TAPS*IN_W-1:0] in_data,
   output logic                   busy,
   output logic                   done,
   output logic [ACC_W-1:0]       result
);
   generate
      if (N_TAPS < 1 || N_TAPS > 12) begin : g_bad_taps
         $error("N_TAPS must be between 1 and 12");
      end
      if (IN_W < 2) begin : g_bad_in
         $error("IN_W must be at least 2");
      end
      if (LUT_W < min_lut_width(IN_W, N_TAPS)) begin : g_bad_lut
         $error("LUT_W too narrow for the weight subset sums");
      end
      if (ACC_W < LUT_W + IN_W) begin : g_bad_acc
         $error("ACC_W too narrow for overflow-free accumulation");
      end
   endgenerate

   logic              accept;
   logic              rd_en;
   logic [N_TAPS-1:0] slice_addr;
   logic              step_vld;
   logic              step_sub;
   logic [LUT_W-1:0]  part_sum;
   logic              wr_ok;

   assign wr_ok = tbl_we && !busy;

   da_slice_seq #(.N_TAPS(N_TAPS), .IN_W(IN_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .in_data    (in_data),
      .busy       (busy),
      .accept     (accept),
      .rd_en      (rd_en),
      .slice_addr (slice_addr),
      .step_vld   (step_vld),
      .step_sub   (step_sub),
      .done       (done)
   );

   da_lut_mem #(.ADDR_W(N_TAPS), .DATA_W(LUT_W)) u_lut (
      .clk     (clk),
      .wr_en   (wr_ok),
      .wr_addr (tbl_addr),
      .wr_data (tbl_wdata),
      .rd_en   (rd_en),
      .rd_addr (slice_addr),
      .rd_data (part_sum)
   );

   da_shift_acc #(.LUT_W(LUT_W), .ACC_W(ACC_W), .ADDER_RIPPLE(ADDER_RIPPLE)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .step_vld (step_vld),
      .step_sub (step_sub),
      .part_sum (part_sum),
      .acc      (result)
   );
endmodule

// File: rtl/da_conv_checker.sv
module da_conv_checker #(
   parameter int IN_W  = 8,
   parameter int ACC_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [ACC_W-1:0] result
);
   localparam int CNT_W = $clog2(IN_W + 2) + 1;

   logic [CNT_W-1:0] cnt;
   logic             hold;
   logic             acc_start;

   assign acc_start = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         hold <= 1'b0;
      end else begin
         if (acc_start)
            cnt <= CNT_W'(IN_W + 1);
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
         if (acc_start)
            hold <= 1'b0;
         else if (done)
            hold <= 1'b1;
      end
   end

   assert_done_on_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(1)) |=> done);

   assert_done_only_on_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != CNT_W'(1)) |=> !done);

   assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy == (cnt != '0));

   assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cnt > CNT_W'(1)) |=> busy);

   assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !acc_start) |=> $stable(result));
endmodule

bind da_conv_engine da_conv_checker #(.IN_W(IN_W), .ACC_W(ACC_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .result (result)
);

// File: tb/tb_da_conv_engine.sv
module tb_da_conv_engine;
   localparam int N     = 9;
   localparam int W     = 8;
   localparam int LW    = 12;
   localparam int AW    = 20;
   localparam int NVEC  = 6;

   localparam logic [N*W-1:0] VECS [NVEC] = '{
      72'h000000000000000001,
      72'h7F7F7F7F7F7F7F7F7F,
      72'h808080808080808080,
      72'h090807060504030201,
      72'hFF01FF01FF01FF01FF,
      72'h807F00FF40C03F8102
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tbl_we = 1'b0;
   logic [N-1:0] tbl_addr = '0;
   logic [LW-1:0] tbl_wdata = '0;
   logic start = 1'b0;
   logic [N*W-1:0] in_data = '0;
   logic busy, done;
   logic [AW-1:0] result;

   int total = 0;
   int passed = 0;
   int wts [N];
   int seed = 32'h1d2b3c4f;

   always #10 clk = ~clk;

   da_conv_engine dut (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_wdata(tbl_wdata), .start(start), .in_data(in_data),
      .busy(busy), .done(done), .result(result)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (ok) passed++;
      else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
   endtask

   function automatic int mac(input logic [N*W-1:0] v);
      int s = 0;
      for (int i = 0; i < N; i++)
         s += int'($signed(v[i*W +: W])) * wts[i];
      return s;
   endfunction

   task automatic load_table();
      for (int a = 0; a < (1 << N); a++) begin
         int s = 0;
         for (int i = 0; i < N; i++)
            if (a[i]) s += wts[i];
         @(negedge clk);
         tbl_we    = 1'b1;
         tbl_addr  = N'(a);
         tbl_wdata = LW'(s);
      end
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   // mode 0 plain, 1 start while busy, 2 input change after capture, 3 table write while busy
   task automatic run_conv(input logic [N*W-1:0] v, input int mode, input string req);
      int exp;
      logic [AW-1:0] held;
      exp = mac(v);
      @(negedge clk);
      in_data = v;
      start   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < W; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k == 2) begin
            if (mode == 1) begin start = 1'b1; in_data = ~v; end
            if (mode == 2) in_data = ~v;
            if (mode == 3) begin
               tbl_we = 1'b1; tbl_addr = '1; tbl_wdata = LW'(12'h5A5);
            end
         end
         if (k == 3) begin
            start = 1'b0; tbl_we = 1'b0;
         end
      end
      chk(done == 1'b0, "R2", "done not yet", int'(done), 0);
      chk(busy == 1'b1, "R3", "busy during run", int'(busy), 1);
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b1, "R2", "done on time", int'(done), 1);
      chk(busy == 1'b0, "R3", "busy low at done", int'(busy), 0);
      chk(int'($signed(result)) == exp, req, "result", int'($signed(result)), exp);
      held = result;
      in_data = ~v;
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R2", "done one cycle", int'(done), 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(result == held, "R6", "result held", int'($signed(result)), int'($signed(held)));
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #3;
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R9", "reset busy", int'(busy), 0);
      chk(done == 1'b0, "R9", "reset done", int'(done), 0);
      chk(result == '0, "R9", "reset result", int'($signed(result)), 0);

      for (int i = 0; i < N; i++) begin
         seed = seed * 1103515245 + 12345;
         wts[i] = int'($signed(8'(seed >>> 16)));
      end
      load_table();

      // R1 main function over the vector table, R8 sign slice in vector 2
      for (int n = 0; n < NVEC; n++)
         run_conv(VECS[n], 0, (n == 2) ? "R8" : "R1");

      run_conv(72'h0F80F0017E11C3FF20, 1, "R4");
      run_conv(72'h1122334455667788F9, 2, "R5");
      run_conv({N*W{1'b1}}, 3, "R7");
      run_conv({N*W{1'b1}}, 0, "R7");

      for (int i = 0; i < N; i++) wts[i] = -128;
      load_table();
      run_conv(72'h808080808080808080, 0, "R10");
      chk(mac(72'h808080808080808080) == 147456, "R10", "model max", mac(72'h808080808080808080), 147456);
      run_conv(72'h7F7F7F7F7F7F7F7F7F, 0, "R10");

      for (int i = 0; i < N; i++) wts[i] = (i % 2 == 0) ? 127 : -1 - 2 * i;
      load_table();
      run_conv(72'h10F0807F01FE33CC80, 0, "R1");

      $display("%0d/%0d checks passed", passed, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 200000, 0);
      $display("%0d/%0d checks passed", passed, total);
      $finish;
   end
endmodule